// File: doc/BRIEF.md
# Pixel Degamma Linearizer

This block sits ahead of the pipe colour matrix and turns gamma-encoded 16-bit pixel channels into linear values. It keeps a single table of 35 unsigned 16-bit knots that all three channels share. Knots 0 to 32 cover the input range 0 to full scale, and knots 33 and 34 are spare headroom entries for values above full scale. Each channel's top five bits pick a segment. The remaining eleven bits interpolate linearly between that knot and the next one.

Software loads and inspects the table through two registers on a simple write/read bus: a pointer register and an entry-data register. When auto-advance is turned on, each access to the entry-data register moves the pointer forward by one. A write that turns auto-advance on does not change the pointer, so software first writes the pointer with auto-advance off (for example to 0) and then writes it again with auto-advance on. Pixels arrive as a valid/ready stream of RGB triples and leave two cycles later. When the colour-conversion enable is low, they pass through unchanged.

Top module: `lin_degamma`

## Requirements
- R1: After reset every table entry reads 0, the pointer reads 0, auto-advance is off and `outValid` is low.
- R2: A read at `regAddr`=0 returns the pointer in bits 5:0 and the auto-advance flag in bit 10, with all other bits 0. A read at `regAddr`=1 returns the entry at the pointer in the same cycle.
- R3: A pointer-register write with bit 10 set turns auto-advance on and leaves the pointer unchanged. A write with bit 10 clear turns auto-advance off and loads bits 5:0 into the pointer, saturating values above 34 to 34.
- R4: A data-register write stores the 16-bit value at the pointer. With auto-advance on, the pointer then steps by one and stays at 34 once it reaches 34.
- R5: A data-register read with auto-advance on steps the pointer in the same way as R4. With auto-advance off the pointer does not move.
- R6: With `cscEn` high, each channel x produces T[s] + floor((T[s+1]-T[s])*f / 2048), where s = x>>11, f = x mod 2048 and the difference is signed. The same table T is used for red, green and blue.
- R7: With `cscEn` low at the cycle a pixel is accepted, that pixel leaves with all three channels unchanged.
- R8: With `outReady` held high, a pixel accepted at clock edge k is presented with `outValid` high after edge k+1 and not before.
- R9: While `outValid` is high and `outReady` is low, the output pixel and `outValid` hold. No pixel is dropped or duplicated.
- R10: If a data-register write and a read arrive in the same cycle, the write takes effect and the pointer advances at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 selects the pointer register, 1 selects the entry-data register |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, valid in the cycle of the read |
| cscEn | input | 1 | Colour-conversion enable; low selects bypass |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Input pixel accepted when high together with inValid |
| inR | input | 16 | Input red |
| inG | input | 16 | Input green |
| inB | input | 16 | Input blue |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream ready |
| outR | output | 16 | Output red |
| outG | output | 16 | Output green |
| outB | output | 16 | Output blue |

## Verification
A wrong pointer shows up on the very next read of either register, because the pointer register echoes it and the data register returns the entry it points at. Stepping past 34, or stepping twice, therefore appears within one access. A corrupted knot shows at the next pixel whose segment touches it, two cycles after that pixel is accepted. A stall-handling fault shows as a changed or missing output while `outReady` is low. Because of this, the reference model compares every register read and every output handshake as it happens, rather than only at the end.

// File: rtl/lin_degamma_pkg.sv
`timescale 1ns/1ps
package lin_degamma_pkg;
  localparam int ENTRY_W      = 16;
  localparam int SEG_BITS     = 5;
  localparam int FRAC_W       = ENTRY_W - SEG_BITS;
  localparam int SPAN_ENTRIES = (1 << SEG_BITS) + 1;
  localparam int OVER_ENTRIES = 2;
  localparam int NUM_ENTRIES  = SPAN_ENTRIES + OVER_ENTRIES;
  localparam int IDX_W        = $clog2(NUM_ENTRIES);
  localparam int LAST_IDX     = NUM_ENTRIES - 1;
  localparam int AUTO_BIT     = 10;
  localparam int REG_W        = ENTRY_W;
  localparam int CHANNELS     = 3;

  typedef logic [CHANNELS-1:0][ENTRY_W-1:0] pix_t;

  typedef struct packed {
    logic               we;
    logic [IDX_W-1:0]   idx;
    logic [ENTRY_W-1:0] data;
  } tblStrobe_t;
endpackage

// File: rtl/lin_degamma_ctrl.sv
`timescale 1ns/1ps
module lin_degamma_ctrl
  import lin_degamma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic [ENTRY_W-1:0] rdEntry,
  output logic [REG_W-1:0] regRdData,
  output tblStrobe_t       strobe
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LAST_IDX);

  logic [IDX_W-1:0] idxQ;
  logic             autoIncQ;
  logic             atTop, wrPtr, wrData, rdData;
  logic [IDX_W-1:0] ptrLoad;

  assign atTop  = (idxQ == TOP_IDX);
  assign wrPtr  = regWrEn && !regAddr;
  assign wrData = regWrEn && regAddr;
  assign rdData = regRdEn && !regWrEn && regAddr;
  assign ptrLoad = (regWrData[IDX_W-1:0] > TOP_IDX) ? TOP_IDX : regWrData[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      autoIncQ <= 1'b0;
    end else if (wrPtr) begin
      if (regWrData[AUTO_BIT]) begin
        autoIncQ <= 1'b1;
      end else begin
        autoIncQ <= 1'b0;
        idxQ     <= ptrLoad;
      end
    end else if ((wrData || rdData) && autoIncQ && !atTop) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) begin
      regRdData = rdEntry;
    end else begin
      regRdData[IDX_W-1:0] = idxQ;
      regRdData[AUTO_BIT]  = autoIncQ;
    end
  end

  assign strobe.we   = wrData;
  assign strobe.idx  = idxQ;
  assign strobe.data = regWrData;

  assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= TOP_IDX);

  assert_autoinc_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && autoIncQ && !atTop) |=> (idxQ == $past(idxQ) + 1'b1));

  assert_enable_keeps_ptr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr && regWrData[AUTO_BIT]) |=> ($stable(idxQ) && autoIncQ));

  assert_noauto_read_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && !autoIncQ) |=> $stable(idxQ));
endmodule

// File: rtl/lin_degamma_path.sv
`timescale 1ns/1ps
module lin_degamma_path
  import lin_degamma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tblStrobe_t         strobe,
  output logic [ENTRY_W-1:0] rdEntry,
  input  logic               cscEn,
  input  logic               inValid,
  output logic               inReady,
  input  pix_t               inPix,
  output logic               outValid,
  input  logic               outReady,
  output pix_t               outPix
);
  localparam int PROD_W = ENTRY_W + FRAC_W + 2;
  localparam int SUM_W  = ENTRY_W + 3;

  logic [ENTRY_W-1:0] tbl [NUM_ENTRIES];
  logic v1, v2, byp1, en1, en2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (strobe.we) begin
      tbl[strobe.idx] <= strobe.data;
    end
  end

  assign rdEntry = tbl[strobe.idx];

  assign en2     = !v2 || outReady;
  assign en1     = !v1 || en2;
  assign inReady = en1;
  assign outValid = v2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1   <= 1'b0;
      v2   <= 1'b0;
      byp1 <= 1'b0;
    end else begin
      if (en1) begin
        v1 <= inValid;
        if (inValid) byp1 <= !cscEn;
      end
      if (en2) v2 <= v1;
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : gChan
    logic [SEG_BITS-1:0] seg;
    logic [IDX_W-1:0]    loIdx;
    logic [ENTRY_W-1:0]  lo1, hi1, raw1, pix2, res;
    logic [FRAC_W-1:0]   fr1;
    logic signed [ENTRY_W:0]   diff;
    logic signed [PROD_W-1:0]  prod, step;
    logic signed [SUM_W-1:0]   sum;

    assign seg   = inPix[c][ENTRY_W-1 -: SEG_BITS];
    assign loIdx = IDX_W'(seg);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lo1 <= '0; hi1 <= '0; raw1 <= '0; fr1 <= '0;
      end else if (en1 && inValid) begin
        lo1  <= tbl[loIdx];
        hi1  <= tbl[loIdx + IDX_W'(1)];
        fr1  <= inPix[c][FRAC_W-1:0];
        raw1 <= inPix[c];
      end
    end

    always_comb begin
      diff = $signed({1'b0, hi1}) - $signed({1'b0, lo1});
      prod = diff * $signed({1'b0, fr1});
      step = prod >>> FRAC_W;
      sum  = $signed({3'b000, lo1}) + step[SUM_W-1:0];
      if (byp1)                               res = raw1;
      else if (sum < 0)                       res = '0;
      else if (sum > $signed(SUM_W'({ENTRY_W{1'b1}}))) res = '1;
      else                                    res = sum[ENTRY_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)          pix2 <= '0;
      else if (en2 && v1) pix2 <= res;
    end

    assign outPix[c] = pix2;
  end

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (v2 && !outReady) |=> (v2 && $stable(outPix)));

  assert_entry_written_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.we |=> (tbl[$past(strobe.idx)] == $past(strobe.data)));

  assert_full_blocks_input_R9: assert property (@(posedge clk) disable iff (!rstN)
    (v1 && v2 && !outReady) |-> !inReady);
endmodule

// File: rtl/lin_degamma.sv
`timescale 1ns/1ps
module lin_degamma
  import lin_degamma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic               regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               cscEn,
  input  logic               inValid,
  output logic               inReady,
  input  logic [ENTRY_W-1:0] inR,
  input  logic [ENTRY_W-1:0] inG,
  input  logic [ENTRY_W-1:0] inB,
  output logic               outValid,
  input  logic               outReady,
  output logic [ENTRY_W-1:0] outR,
  output logic [ENTRY_W-1:0] outG,
  output logic [ENTRY_W-1:0] outB
);
  tblStrobe_t         strobe;
  logic [ENTRY_W-1:0] rdEntry;
  pix_t               inPix, outPix;

  assign inPix = {inB, inG, inR};
  assign outR  = outPix[0];
  assign outG  = outPix[1];
  assign outB  = outPix[2];

  lin_degamma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .rdEntry(rdEntry),
    .regRdData(regRdData), .strobe(strobe)
  );

  lin_degamma_path u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdEntry(rdEntry),
    .cscEn(cscEn), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .outValid(outValid), .outReady(outReady), .outPix(outPix)
  );
endmodule

// File: tb/lin_degamma_tb.sv
`timescale 1ns/1ps
module lin_degamma_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        cscEn = 1'b1, inValid = 1'b0, outReady = 1'b1;
  logic        inReady, outValid;
  logic [15:0] inR = '0, inG = '0, inB = '0, outR, outG, outB;

  lin_degamma u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cscEn(cscEn), .inValid(inValid), .inReady(inReady),
    .inR(inR), .inG(inG), .inB(inB), .outValid(outValid),
    .outReady(outReady), .outR(outR), .outG(outG), .outB(outB)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  string curTag = "R2";
  bit bpMode = 1'b0;
  int unsigned seed = 32'h1234_5678;

  int  mTbl [35];
  int  mIdx = 0;
  bit  mAuto = 1'b0;
  logic [48:0] expQ [$];
  bit  prevStall = 1'b0;
  logic [47:0] prevPix = '0;

  function automatic int unsigned nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int interp(input int x);
    int s, f, a, b, p, r;
    s = x >> 11; f = x & 2047;
    a = mTbl[s]; b = mTbl[s + 1];
    p = (b - a) * f;
    r = a + (p >>> 11);
    if (r < 0) r = 0;
    if (r > 65535) r = 65535;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, evaluated mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (regRdEn) begin
        int e;
        e = regAddr ? mTbl[mIdx] : ((int'(mAuto) << 10) | mIdx);
        check(regRdData == 16'(e), curTag, 64'(regRdData), 64'(e));
      end
      if (prevStall)
        check(outValid && ({outB, outG, outR} == prevPix), "R9", {15'd0, outValid, outB, outG, outR}, {16'd1, prevPix});
      prevStall = outValid && !outReady;
      prevPix   = {outB, outG, outR};
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9", {16'd0, outB, outG, outR}, 64'd0);
        end else begin
          logic [48:0] e;
          e = expQ.pop_front();
          check({outB, outG, outR} == e[47:0], e[48] ? "R7" : "R6", {16'd0, outB, outG, outR}, {16'd0, e[47:0]});
        end
      end
      if (inValid && inReady) begin
        if (!cscEn) expQ.push_back({1'b1, inB, inG, inR});
        else expQ.push_back({1'b0, 16'(interp(inB)), 16'(interp(inG)), 16'(interp(inR))});
      end
      if (regWrEn) begin
        if (!regAddr) begin
          if (regWrData[10]) mAuto = 1'b1;
          else begin
            mAuto = 1'b0;
            mIdx = (int'(regWrData[5:0]) > 34) ? 34 : int'(regWrData[5:0]);
          end
        end else begin
          mTbl[mIdx] = int'(regWrData);
          if (mAuto && mIdx < 34) mIdx++;
        end
      end else if (regRdEn && regAddr && mAuto && mIdx < 34) begin
        mIdx++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (bpMode) outReady = nextRand() % 3 != 0;
    else outReady = 1'b1;
  end

  task automatic regOp(input bit wr, input bit rd, input bit addr, input logic [15:0] d, input string tag);
    curTag = tag; regWrEn = wr; regRdEn = rd; regAddr = addr; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regRdEn = 1'b0;
  endtask

  task automatic sendPix(input logic [15:0] r, input logic [15:0] g, input logic [15:0] b, input bit csc);
    bit acc;
    inR = r; inG = g; inB = b; cscEn = csc; inValid = 1'b1;
    forever begin
      @(negedge clk); acc = inReady;
      @(posedge clk); #1;
      if (acc) break;
    end
    inValid = 1'b0;
  endtask

  task automatic burst(input int n, input bit csc);
    for (int k = 0; k < n; k++) begin
      sendPix(16'(nextRand()), 16'(nextRand()), 16'(nextRand()), csc);
      if (bpMode && (nextRand() % 4 == 0)) begin @(posedge clk); #1; end
    end
  endtask

  task automatic loadTable(input bit linear);
    regOp(1, 0, 0, 16'd0, "R3");
    regOp(1, 0, 0, 16'h0400, "R3");
    for (int i = 0; i < 35; i++) begin
      int v;
      if (linear) v = (i <= 32) ? (i * 65535) / 32 : 65535;
      else v = (i % 2) ? 60000 - i * 700 : i * 900;
      regOp(1, 0, 1, 16'(v), "R4");
    end
  endtask

  task automatic drain();
    bpMode = 1'b0;
    repeat (8) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 35; i++) mTbl[i] = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(outValid == 1'b0, "R1", 64'(outValid), 64'd0);
    @(posedge clk); #1;
    regOp(0, 1, 0, 16'd0, "R1");
    regOp(1, 0, 0, 16'h0400, "R1");
    for (int i = 0; i < 36; i++) regOp(0, 1, 1, 16'd0, "R1");
    regOp(0, 1, 0, 16'd0, "R5");

    // R3: auto-advance enable ignores index bits; saturation of loaded pointer
    regOp(1, 0, 0, 16'd7, "R3");
    regOp(0, 1, 0, 16'd0, "R2");
    regOp(1, 0, 0, 16'h0400 | 16'd20, "R3");
    regOp(0, 1, 0, 16'd0, "R3");
    regOp(1, 0, 0, 16'd50, "R3");
    regOp(0, 1, 0, 16'd0, "R3");
    regOp(1, 0, 0, 16'd63, "R3");
    regOp(0, 1, 1, 16'd0, "R2");

    // R4: load linear table with auto-advance, pointer stops at 34
    loadTable(1'b1);
    regOp(0, 1, 0, 16'd0, "R4");
    regOp(1, 0, 1, 16'hFFFF, "R4");
    regOp(0, 1, 0, 16'd0, "R4");

    // R5: reads with and without auto-advance
    regOp(1, 0, 0, 16'd30, "R5");
    regOp(0, 1, 1, 16'd0, "R5");
    regOp(0, 1, 1, 16'd0, "R5");
    regOp(0, 1, 0, 16'd0, "R5");
    regOp(1, 0, 0, 16'h0400, "R5");
    for (int i = 0; i < 6; i++) regOp(0, 1, 1, 16'd0, "R5");
    regOp(0, 1, 0, 16'd0, "R5");

    // R10: simultaneous write and read of the data register
    regOp(1, 0, 0, 16'd5, "R10");
    regOp(1, 0, 0, 16'h0400, "R10");
    regOp(1, 1, 1, 16'(5 * 65535 / 32), "R10");
    regOp(0, 1, 0, 16'd0, "R10");
    regOp(1, 0, 0, 16'd5, "R10");
    regOp(0, 1, 1, 16'd0, "R10");

    // R8: latency with an empty pipe
    drain();
    sendPix(16'd4096, 16'd100, 16'd65535, 1'b1);
    @(negedge clk);
    check(outValid == 1'b0, "R8", 64'(outValid), 64'd0);
    @(negedge clk);
    check(outValid == 1'b1, "R8", 64'(outValid), 64'd1);
    @(posedge clk); #1;

    // R6: corner inputs and random pixels on identity table
    sendPix(16'd0, 16'd2047, 16'd2048, 1'b1);
    sendPix(16'd65535, 16'd63488, 16'd1023, 1'b1);
    burst(40, 1'b1);

    // R9: random backpressure with gaps
    bpMode = 1'b1;
    burst(150, 1'b1);

    // R7: bypass, with and without backpressure
    burst(40, 1'b0);
    bpMode = 1'b0;
    sendPix(16'd1234, 16'd65535, 16'd0, 1'b0);
    drain();

    // R6: non-monotone table gives negative slopes
    loadTable(1'b0);
    sendPix(16'd2047, 16'd4095, 16'd63000, 1'b1);
    burst(40, 1'b1);
    bpMode = 1'b1;
    burst(100, 1'b1);
    drain();

    // R9: nothing left behind
    @(negedge clk);
    check(expQ.size() == 0, "R9", 64'(expQ.size()), 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule